// File: doc/BRIEF.md
# Dual-Channel High/Low PWM Generator

Two independent pulse-width channels share one small register set. Each channel drives its pin high for a programmed number of ticks, then low for a second programmed number, and repeats. The tick for a channel comes from one of four tick-enable inputs, divided down by a 7-bit prescaler. All sources are modelled as single-cycle enables in one system clock domain.

Software writes a 32-bit count word per channel and one shared control word through a simple synchronous bus. The bus has a word address, a write strobe and write data, with read data that follows the address in the same cycle. The control word gives each channel its enable, its clock gate, its source select, its prescaler, a polarity invert and a constant-level mode. A count word written while a channel runs is held back until the current period ends, so a phase is never cut short.

Top module: `hilo_pwm_pair`

## Requirements
- R1: After reset every register reads 0 and both outputs are low.
- R2: A count word holds the high-phase tick count in bits 31:16 and the low-phase tick count in bits 15:0. A running channel, with constant mode off and both counts non-zero, starts in its high phase. It stays high for that many ticks, then low for the low count, and so repeats with period high+low ticks.
- R3: One channel tick occurs per (P+1) ticks of the selected source, where P is the prescaler field: control bits 14:8 for channel A and bits 22:16 for channel B. P=0 ticks on every source tick.
- R4: The source select field, control bits 5:4 for A and 7:6 for B, picks the tick input src_tick[sel] that drives the channel. A source that never ticks freezes the waveform.
- R5: A channel runs only when its enable bit (bit 0 for A, bit 1 for B) and its clock gate bit (bit 15 for A, bit 23 for B) are both set. Otherwise it drives its idle level. On the next activation it restarts at the start of a high phase.
- R6: Invert bit 26 (A) or 27 (B) inverts the output, both while the channel runs and on the idle level. The idle level is therefore low, or high when invert is set.
- R7: With constant bit 28 (A) or 29 (B) set, a high count of 0 gives a steady low with no pulse. A low count of 0 with a non-zero high count gives a steady high. When both counts are non-zero the waveform is the normal one.
- R8: With constant mode off, a zero count still lasts one tick. So high=0xFFFF with low=0 is low for exactly one tick per period, and high=0 with low=L gives one high tick, then L low ticks. When both counts are 0 the output is low.
- R9: A count word written while its channel runs takes effect at the next period boundary, that is, after the low phase ends. While the channel is idle it takes effect at once.
- R10: Word address 0 is the channel A count, 1 is the channel B count and 2 is control. Address 3 is not writable. Every register reads back what was written, and the two channels run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| src_tick | input | 4 | Four tick-enable sources |
| pwm_out | output | 2 | Channel outputs, bit 0 is A, bit 1 is B |

## Verification
The bench compares each output cycle by cycle against a tick-position model. It aims at the zero-count corners: a design that dropped the one-tick rule would hold high=0xFFFF/low=0 steady high. A design that let constant mode slip would show a one-tick glitch on a steady level. It rewrites a count word mid-period, which exposes a design that applies counts at once, because that design shortens the running high phase. It also checks the idle level under invert, and a restart after disable. A design that kept stale phase state would start that restart mid-waveform.

// File: rtl/hilo_pwm_pkg.sv
package hilo_pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int NSRC   = 4;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int NCH    = 2;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic             inv;
    logic             cnst;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  // control-word fields of channel ch
  function automatic chan_cfg_t decode_cfg(input logic [WORD_W-1:0] ctl, input int ch);
    chan_cfg_t c;
    c.en   = ctl[ch];
    c.sel  = ctl[4 + 2*ch +: SEL_W];
    c.div  = ctl[8 + 8*ch +: DIV_W];
    c.gate = ctl[15 + 8*ch];
    c.inv  = ctl[26 + ch];
    c.cnst = ctl[28 + ch];
    return c;
  endfunction

  // a zero count still occupies one tick
  function automatic logic [CNT_W-1:0] phase_len(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

  // un-inverted level from latched counts and current phase
  function automatic logic wave_level(input logic cnst, input logic [CNT_W-1:0] hi,
                                      input logic [CNT_W-1:0] lo, input logic in_hi);
    if (hi == '0 && (cnst || lo == '0)) return 1'b0;
    if (cnst && lo == '0)               return 1'b1;
    return in_hi;
  endfunction
endpackage

// File: rtl/hilo_pwm_regs.sv
module hilo_pwm_regs
  import hilo_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] cnt_word [NCH],
  output logic [WORD_W-1:0] ctl_word
);
  localparam logic [1:0] CTL_ADDR = 2'd2;

  for (genvar g = 0; g < NCH; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt_word[g] <= '0;
      else if (bus_we && bus_addr == 2'(g))      cnt_word[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctl_word <= '0;
    else if (bus_we && bus_addr == CTL_ADDR) ctl_word <= bus_wdata;
  end

  always_comb begin
    case (bus_addr)
      2'd0:     bus_rdata = cnt_word[0];
      2'd1:     bus_rdata = cnt_word[1];
      CTL_ADDR: bus_rdata = ctl_word;
      default:  bus_rdata = '0;
    endcase
  end

  assert_ctl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && bus_addr == CTL_ADDR |=> ctl_word == $past(bus_wdata));
endmodule

// File: rtl/hilo_pwm_prescale.sv
module hilo_pwm_prescale
  import hilo_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick_o
);
  logic [DIV_W-1:0] pcnt;
  logic             src_sel;
  logic             wrap;

  assign src_sel = src_tick[sel];
  assign wrap    = (pcnt >= div);
  assign tick_o  = active && src_sel && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (!active) pcnt <= '0;
    else if (src_sel) pcnt <= wrap ? '0 : pcnt + 1'b1;
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> pcnt == '0);
endmodule

// File: rtl/hilo_pwm_engine.sv
module hilo_pwm_engine
  import hilo_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             cnst,
  input  logic             inv,
  input  logic [CNT_W-1:0] shadow_hi,
  input  logic [CNT_W-1:0] shadow_lo,
  output logic             out_o
);
  logic             in_hi;
  logic [CNT_W-1:0] cnt, hi_q, lo_q;
  logic [CNT_W-1:0] cur_len;
  logic             phase_done;
  logic             period_end;

  assign cur_len    = in_hi ? phase_len(hi_q) : phase_len(lo_q);
  assign phase_done = tick && (cnt == cur_len - 1'b1);
  assign period_end = phase_done && !in_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hi <= 1'b1; cnt <= '0; hi_q <= '0; lo_q <= '0;
    end else if (!active) begin
      in_hi <= 1'b1; cnt <= '0; hi_q <= shadow_hi; lo_q <= shadow_lo;
    end else if (phase_done) begin
      cnt <= '0;
      in_hi <= !in_hi;
      if (!in_hi) begin
        hi_q <= shadow_hi;
        lo_q <= shadow_lo;
      end
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign out_o = active ? (wave_level(cnst, hi_q, lo_q, in_hi) ^ inv) : inv;

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> in_hi && cnt == '0);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt < cur_len);
  assert_const_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active && cnst && hi_q == '0 |-> out_o == inv);
  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active && !period_end |=> $stable(hi_q) && $stable(lo_q));
endmodule

// File: rtl/hilo_pwm_pair.sv
module hilo_pwm_pair
  import hilo_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-1:0]    pwm_out
);
  logic [WORD_W-1:0] cnt_word [NCH];
  logic [WORD_W-1:0] ctl_word;

  hilo_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_word(cnt_word), .ctl_word(ctl_word)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_cfg_t cfg;
    logic      active;
    logic      tick;

    assign cfg    = decode_cfg(ctl_word, g);
    assign active = cfg.en && cfg.gate;

    hilo_pwm_prescale u_pre (
      .clk(clk), .rst_n(rst_n), .active(active), .src_tick(src_tick),
      .sel(cfg.sel), .div(cfg.div), .tick_o(tick)
    );

    hilo_pwm_engine u_eng (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
      .cnst(cfg.cnst), .inv(cfg.inv),
      .shadow_hi(cnt_word[g][WORD_W-1 -: CNT_W]),
      .shadow_lo(cnt_word[g][CNT_W-1:0]),
      .out_o(pwm_out[g])
    );

    assert_idle_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> pwm_out[g] == ctl_word[26 + g]);
  end
endmodule

// File: tb/hilo_pwm_pair_test.sv
module hilo_pwm_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick = 4'b1001;
  logic [1:0]  pwm_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  hilo_pwm_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_tick(src_tick), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 2'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  function automatic logic [31:0] chan_bits(input int ch, input bit en, input bit gate,
      input bit iv, input bit cn, input int sel, input int dv);
    logic [31:0] w = '0;
    w[ch] = en;
    w[4 + 2*ch +: 2] = 2'(sel);
    w[8 + 8*ch +: 7] = 7'(dv);
    w[15 + 8*ch] = gate;
    w[26 + ch] = iv;
    w[28 + ch] = cn;
    return w;
  endfunction

  // level expected k cycles after activation with a source ticking every cycle
  function automatic bit exp_level(input int hi, input int lo, input bit cn, input bit iv,
      input int dv, input int k);
    int t = k / (dv + 1);
    int h = (hi == 0) ? 1 : hi;
    int l = (lo == 0) ? 1 : lo;
    bit raw;
    if (hi == 0 && (cn || lo == 0)) raw = 0;
    else if (cn && lo == 0)         raw = 1;
    else                            raw = ((t % (h + l)) < h);
    return raw ^ iv;
  endfunction

  task automatic run_cmp(input int ch, input int hi, input int lo, input bit cn, input bit iv,
      input int sel, input int dv, input int n, input string req);
    int bad = 0; int fk = 0; bit fa = 0; bit fe = 0;
    wr(2, 0);
    wr(ch, {16'(hi), 16'(lo)});
    wr(2, chan_bits(ch, 1, 1, iv, cn, sel, dv));
    for (int k = 0; k < n; k++) begin
      bit e = exp_level(hi, lo, cn, iv, dv, k);
      if (pwm_out[ch] !== e) begin
        if (bad == 0) begin fk = k; fa = pwm_out[ch]; fe = e; end
        bad++;
      end
      @(negedge clk);
    end
    if (bad != 0) $display("  first mismatch at cycle %0d of %s", fk, req);
    chk(bad == 0, req, fa, fe);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 3; a++) begin
      bus_addr = 2'(a); #1;
      chk(bus_rdata == 0, "R1 register reset", bus_rdata, 0);
    end
    chk(pwm_out == 2'b00, "R1 output reset", pwm_out, 0);
  endtask

  task automatic t_readback;
    wr(0, 32'h1234_5678); wr(1, 32'h9abc_def0); wr(2, 32'h0055_aa00); wr(3, 32'hffff_ffff);
    bus_addr = 0; #1; chk(bus_rdata == 32'h1234_5678, "R10 count A readback", bus_rdata, 32'h1234_5678);
    bus_addr = 1; #1; chk(bus_rdata == 32'h9abc_def0, "R10 count B readback", bus_rdata, 32'h9abc_def0);
    bus_addr = 2; #1; chk(bus_rdata == 32'h0055_aa00, "R10 control readback", bus_rdata, 32'h0055_aa00);
    bus_addr = 3; #1; chk(bus_rdata == 0, "R10 address 3 not writable", bus_rdata, 0);
    wr(2, 0);
  endtask

  task automatic t_idle;
    wr(0, {16'd1, 16'd1});
    wr(2, chan_bits(0, 0, 1, 1, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R6 disabled idle high under invert", pwm_out[0], 1);
    wr(2, chan_bits(0, 1, 0, 1, 0, 0, 0));
    begin
      int low = 0;
      for (int k = 0; k < 10; k++) begin if (pwm_out[0] != 1'b1) low++; @(negedge clk); end
      chk(low == 0, "R5 gate off holds idle", low, 0);
    end
    wr(2, chan_bits(0, 1, 0, 0, 0, 0, 0));
    chk(pwm_out[0] == 1'b0, "R5 gate off idle low", pwm_out[0], 0);
    // run, stop mid-phase, restart: must begin at a fresh high phase
    wr(0, {16'd3, 16'd3});
    wr(2, chan_bits(0, 1, 1, 0, 0, 0, 0));
    repeat (4) @(negedge clk);
    run_cmp(0, 3, 3, 0, 0, 0, 0, 20, "R5 restart from high phase");
  endtask

  task automatic t_select;
    wr(2, 0);
    wr(1, {16'd1, 16'd1});
    wr(2, chan_bits(1, 1, 1, 0, 0, 1, 0));
    begin
      int moved = 0;
      for (int k = 0; k < 12; k++) begin if (pwm_out[1] != 1'b1) moved++; @(negedge clk); end
      chk(moved == 0, "R4 dead source freezes output", moved, 0);
    end
    run_cmp(1, 1, 1, 0, 0, 3, 0, 20, "R4 source 3 select");
  endtask

  task automatic t_shadow;
    int bad = 0;
    wr(2, 0);
    wr(0, {16'd3, 16'd2});
    wr(2, chan_bits(0, 1, 1, 0, 0, 0, 0));
    wr(0, {16'd2, 16'd4});  // lands at end of cycle 1; now at cycle 2
    for (int k = 2; k < 17; k++) begin
      bit e = (k < 5) ? exp_level(3, 2, 0, 0, 0, k) : exp_level(2, 4, 0, 0, 0, k - 5);
      if (pwm_out[0] !== e) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 count applied at period boundary", bad, 0);
  endtask

  task automatic t_indep;
    int bad = 0;
    wr(2, 0);
    wr(0, {16'd2, 16'd2});
    wr(1, {16'd3, 16'd5});
    wr(2, chan_bits(0, 1, 1, 0, 0, 0, 0) | chan_bits(1, 1, 1, 1, 0, 0, 1));
    for (int k = 0; k < 60; k++) begin
      if (pwm_out[0] !== exp_level(2, 2, 0, 0, 0, k)) bad++;
      if (pwm_out[1] !== exp_level(3, 5, 0, 1, 1, k)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R10 channels independent", bad, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_readback();
    run_cmp(0, 3, 2, 0, 0, 0, 0, 30, "R2 hi3 lo2");
    run_cmp(0, 1, 1, 0, 0, 0, 0, 12, "R2 hi1 lo1");
    run_cmp(1, 5, 7, 0, 0, 0, 0, 40, "R2 channel B hi5 lo7");
    run_cmp(0, 2, 3, 0, 0, 0, 4, 80, "R3 prescale 4");
    run_cmp(1, 1, 1, 0, 0, 0, 127, 600, "R3 prescale 127");
    run_cmp(0, 3, 1, 0, 1, 0, 0, 24, "R6 inverted waveform");
    run_cmp(0, 4, 0, 1, 0, 0, 0, 30, "R7 constant high");
    run_cmp(1, 0, 4, 1, 0, 0, 0, 30, "R7 constant low");
    run_cmp(0, 0, 0, 1, 0, 0, 0, 10, "R7 constant both zero low");
    run_cmp(0, 2, 3, 1, 0, 0, 0, 25, "R7 constant with nonzero counts");
    run_cmp(0, 0, 3, 0, 0, 0, 0, 24, "R8 zero high one tick");
    run_cmp(1, 0, 0, 0, 0, 0, 0, 10, "R8 both zero low");
    run_cmp(0, 16'hffff, 0, 0, 0, 0, 0, 65540, "R8 ffff/0 one low tick");
    t_idle();
    t_select();
    t_shadow();
    t_indep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule